// File: doc/BRIEF.md
# SPI Initiator with Ready Handshake and Burst Gap

This block is the initiator side of a four-wire SPI link. Software-facing logic pushes bytes into an eight-entry transmit queue. The engine clocks each byte out on MOSI while it captures a byte from MISO into an eight-entry receive queue. Clock polarity, clock phase, bit order and the SCLK rate are static configuration inputs. The SCLK rate is the system clock divided by 2 × (1 + divider).

Three options stall or shape the traffic on the wire:
- **Ready handshake.** The target can hold off each byte with an active-high ready line.
- **Idle gap.** A programmable number of idle cycles is inserted after chip select rises and before the next frame.
- **Continuous mode.** Chip select stays low across back-to-back bytes for as long as the transmit queue has data.

A loopback switch feeds MOSI straight back to the receive shifter. An interrupt output stays high while the receive queue holds at least a programmed number of bytes.

Top module: `spim_core`

## Requirements
- R1: Every SCLK half period, the delay from CS falling to the first SCLK edge, and the delay from the last SCLK edge to CS rising each last exactly `cfg_div + 1` clock cycles, provided ready is not holding the engine.
- R2: While CS is high, SCLK rests at `cfg_cpol`. Each byte takes exactly 16 SCLK transitions, and CS only rises after a whole number of bytes.
- R3: With `cfg_cpha` = 0, each data bit is valid on MOSI before the first (leading) SCLK edge of its bit and is sampled on that edge. With `cfg_cpha` = 1, data changes on the leading edge and is sampled on the trailing edge. In both modes MISO is sampled on the same edges as MOSI.
- R4: With `cfg_lsb_first` = 0, bit 7 is sent and received first. With `cfg_lsb_first` = 1, bit 0 is sent and received first.
- R5: With `cfg_flow_en` = 1, once CS has fallen no SCLK edge occurs while `rdy` (active high, two-flop synchronized) is low. The byte proceeds after `rdy` rises. With `cfg_flow_en` = 0, `rdy` has no effect.
- R6: In non-continuous mode, when the next byte is already queued, CS stays high between frames for exactly `cfg_gap + 1` clock cycles.
- R7: With `cfg_cont` = 1, CS falls once for all bytes that are queued back to back, and rises after the last one.
- R8: With `cfg_loopback` = 1, each received byte equals the byte that was sent, and MISO is ignored.
- R9: Each queue holds 8 bytes and reports its level. A push to a full transmit queue is ignored. A byte that completes while the receive queue is full is discarded, and the queued bytes are kept.
- R10: `irq` is high exactly when `rx_level` ≥ `cfg_irq_cnt + 1`, so the threshold ranges from 1 to 8.
- R11: After reset: `cs_n` = 1, `sclk` = `cfg_cpol`, both levels are 0, `rx_empty` = 1 and `irq` = 0.
- R12: A new frame starts only when `cfg_en` = 1. With `cfg_en` = 0, queued bytes stay in the transmit queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Allows frames to start |
| cfg_cpol | input | 1 | Idle level of SCLK |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_lsb_first | input | 1 | 1: bit 0 first |
| cfg_loopback | input | 1 | Feeds MOSI back to the receive shifter |
| cfg_cont | input | 1 | Keeps CS low while bytes are queued |
| cfg_flow_en | input | 1 | Enables the ready handshake |
| cfg_div | input | 6 | SCLK half period minus one, in clock cycles |
| cfg_gap | input | 8 | Extra idle cycles after CS rises |
| cfg_irq_cnt | input | 3 | Interrupt threshold minus one |
| tx_push | input | 1 | Writes tx_wdata into the transmit queue |
| tx_wdata | input | 8 | Byte to send |
| tx_full | output | 1 | Transmit queue full |
| tx_level | output | 4 | Bytes waiting to be sent |
| rx_pop | input | 1 | Removes the head of the receive queue |
| rx_rdata | output | 8 | Head of the receive queue |
| rx_empty | output | 1 | Receive queue empty |
| rx_level | output | 4 | Bytes waiting to be read |
| irq | output | 1 | Receive level has reached the threshold |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, active low |
| rdy | input | 1 | Target ready, active high |

## Verification
The hardest state to reach is a byte that completes while the receive queue is already full. The bench first holds the engine disabled and fills the transmit queue past its limit. It then lets eight bytes run through into the receive queue without popping any, and sends a ninth. With the queue still at level 8, the receive queue is drained one byte at a time. At each level, every threshold setting is swept, so the interrupt is compared across all 72 combinations of level and threshold. A bench model of the target follows the SCLK edges for every polarity, phase and bit order setting, so the bench knows on which edge each bit must appear.

// File: rtl/spim_pkg.sv
package spim_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_LEAD  = 2'd1,
      ST_SHIFT = 2'd2,
      ST_GAP   = 2'd3
   } spim_state_e;
endpackage

// File: rtl/spim_sync.sv
module spim_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] r;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spim_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) r[0] <= 1'b0;
               else        r[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) r[i] <= 1'b0;
               else        r[i] <= r[i-1];
            end
         end
      end
   endgenerate

   assign q = r[STAGES-1];
endmodule

// File: rtl/spim_fifo.sv
module spim_fifo #(
   parameter int DW    = 8,
   parameter int DEPTH = 8,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] rdata,
   output logic          full,
   output logic          empty,
   output logic [LW-1:0] level
);
   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic          do_push, do_pop;

   assign full    = (level == LW'(DEPTH));
   assign empty   = (level == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rd_ptr];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   AST_FIFO_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> (level == $past(level))); // R9
   AST_FIFO_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LW'(DEPTH)); // R9
endmodule

// File: rtl/spim_engine.sv
module spim_engine
   import spim_pkg::*;
#(
   parameter int DW    = 8,
   parameter int DIV_W = 6,
   parameter int GAP_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_en,
   input  logic             cfg_cpol,
   input  logic             cfg_cpha,
   input  logic             cfg_lsb_first,
   input  logic             cfg_loopback,
   input  logic             cfg_cont,
   input  logic             cfg_flow_en,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic [GAP_W-1:0] cfg_gap,
   input  logic             rdy_s,
   input  logic             miso,
   input  logic             tx_empty,
   input  logic [DW-1:0]    tx_rdata,
   output logic             tx_pop,
   input  logic             rx_full,
   output logic             rx_push,
   output logic [DW-1:0]    rx_wdata,
   output logic             sclk,
   output logic             mosi,
   output logic             cs_n
);
   localparam int EDGES = 2 * DW;
   localparam int EC_W  = $clog2(EDGES + 1);

   spim_state_e      st;
   logic [DIV_W-1:0] hcnt;
   logic [EC_W-1:0]  ecnt, ek;
   logic [GAP_W-1:0] gcnt;
   logic [DW-1:0]    tx_sr, rx_sr, rx_ins;
   logic             sclk_q, mosi_q, cs_q;
   logic             tick, go_ok, start, last, more, load, do_edge;
   logic             smp, drv, sin;

   function automatic logic head(input logic [DW-1:0] x, input logic lsb);
      return lsb ? x[0] : x[DW-1];
   endfunction

   function automatic logic [DW-1:0] adv(input logic [DW-1:0] x, input logic lsb);
      return lsb ? (x >> 1) : (x << 1);
   endfunction

   always_comb begin
      tick    = (hcnt == cfg_div);
      go_ok   = !cfg_flow_en || rdy_s;
      start   = (st == ST_IDLE) && cfg_en && !tx_empty;
      last    = (st == ST_SHIFT) && tick && (ecnt == EC_W'(EDGES));
      more    = last && cfg_cont && cfg_en && !tx_empty;
      load    = start || more;
      do_edge = ((st == ST_LEAD) && tick && go_ok) ||
                ((st == ST_SHIFT) && tick && (ecnt != EC_W'(EDGES)));
      ek      = (st == ST_LEAD) ? '0 : ecnt;
      smp     = (ek[0] == cfg_cpha);
      drv     = !smp && !(!cfg_cpha && (ek == EC_W'(EDGES - 1)));
      sin     = cfg_loopback ? mosi_q : miso;
      rx_ins  = cfg_lsb_first ? {sin, rx_sr[DW-1:1]} : {rx_sr[DW-2:0], sin};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         hcnt   <= '0;
         ecnt   <= '0;
         gcnt   <= '0;
         tx_sr  <= '0;
         rx_sr  <= '0;
         sclk_q <= 1'b0;
         mosi_q <= 1'b0;
         cs_q   <= 1'b1;
      end else if (load) begin
         st     <= ST_LEAD;
         hcnt   <= '0;
         ecnt   <= '0;
         cs_q   <= 1'b0;
         sclk_q <= cfg_cpol;
         if (cfg_cpha) begin
            tx_sr <= tx_rdata;
         end else begin
            tx_sr  <= adv(tx_rdata, cfg_lsb_first);
            mosi_q <= head(tx_rdata, cfg_lsb_first);
         end
      end else if (do_edge) begin
         st     <= ST_SHIFT;
         sclk_q <= ~sclk_q;
         ecnt   <= ek + 1'b1;
         hcnt   <= '0;
         if (smp) rx_sr <= rx_ins;
         if (drv) begin
            mosi_q <= head(tx_sr, cfg_lsb_first);
            tx_sr  <= adv(tx_sr, cfg_lsb_first);
         end
      end else begin
         case (st)
            ST_IDLE: begin
               sclk_q <= cfg_cpol;
               cs_q   <= 1'b1;
            end
            ST_LEAD: begin
               if (!tick) hcnt <= hcnt + 1'b1;
            end
            ST_SHIFT: begin
               if (last) begin
                  cs_q <= 1'b1;
                  hcnt <= '0;
                  if (cfg_gap == '0) begin
                     st <= ST_IDLE;
                  end else begin
                     st   <= ST_GAP;
                     gcnt <= cfg_gap - 1'b1;
                  end
               end else if (!tick) begin
                  hcnt <= hcnt + 1'b1;
               end
            end
            default: begin
               sclk_q <= cfg_cpol;
               if (gcnt == '0) st <= ST_IDLE;
               else            gcnt <= gcnt - 1'b1;
            end
         endcase
      end
   end

   assign tx_pop   = load;
   assign rx_push  = last && !rx_full;
   assign rx_wdata = rx_sr;
   assign sclk     = sclk_q;
   assign mosi     = mosi_q;
   assign cs_n     = cs_q;

   AST_READY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_LEAD && cfg_flow_en && !rdy_s) |=> (sclk_q == $past(sclk_q))); // R5
   AST_IDLE_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |=> (sclk_q == $past(cfg_cpol))); // R2
   AST_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_q && (sclk_q != $past(sclk_q)) && (cfg_div != '0) && $stable(cfg_div))
      |=> $stable(sclk_q)); // R1
   AST_CS_WHOLE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_q) |-> (ecnt == EC_W'(EDGES))); // R2
endmodule

// File: rtl/spim_core.sv
module spim_core #(
   parameter int DW          = 8,
   parameter int DEPTH       = 8,
   parameter int DIV_W       = 6,
   parameter int GAP_W       = 8,
   parameter int SYNC_STAGES = 2,
   localparam int LW         = $clog2(DEPTH + 1),
   localparam int CNT_W      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_en,
   input  logic             cfg_cpol,
   input  logic             cfg_cpha,
   input  logic             cfg_lsb_first,
   input  logic             cfg_loopback,
   input  logic             cfg_cont,
   input  logic             cfg_flow_en,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic [GAP_W-1:0] cfg_gap,
   input  logic [CNT_W-1:0] cfg_irq_cnt,
   input  logic             tx_push,
   input  logic [DW-1:0]    tx_wdata,
   output logic             tx_full,
   output logic [LW-1:0]    tx_level,
   input  logic             rx_pop,
   output logic [DW-1:0]    rx_rdata,
   output logic             rx_empty,
   output logic [LW-1:0]    rx_level,
   output logic             irq,
   output logic             sclk,
   output logic             mosi,
   input  logic             miso,
   output logic             cs_n,
   input  logic             rdy
);
   generate
      if (DW < 2) begin : g_bad_dw
         $error("spim_core: DW must be at least 2");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("spim_core: DEPTH must be at least 2");
      end
   endgenerate

   logic          rdy_s, tx_empty, tx_pop, rx_full, rx_push;
   logic [DW-1:0] tx_rdata, rx_wdata;

   spim_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
      .clk(clk), .rst_n(rst_n), .d(rdy), .q(rdy_s)
   );

   spim_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(tx_wdata),
      .pop(tx_pop), .rdata(tx_rdata), .full(tx_full), .empty(tx_empty),
      .level(tx_level)
   );

   spim_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_wdata),
      .pop(rx_pop), .rdata(rx_rdata), .full(rx_full), .empty(rx_empty),
      .level(rx_level)
   );

   spim_engine #(.DW(DW), .DIV_W(DIV_W), .GAP_W(GAP_W)) u_eng (
      .clk(clk), .rst_n(rst_n),
      .cfg_en(cfg_en), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
      .cfg_lsb_first(cfg_lsb_first), .cfg_loopback(cfg_loopback),
      .cfg_cont(cfg_cont), .cfg_flow_en(cfg_flow_en),
      .cfg_div(cfg_div), .cfg_gap(cfg_gap),
      .rdy_s(rdy_s), .miso(miso),
      .tx_empty(tx_empty), .tx_rdata(tx_rdata), .tx_pop(tx_pop),
      .rx_full(rx_full), .rx_push(rx_push), .rx_wdata(rx_wdata),
      .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
   );

   assign irq = (rx_level >= (LW'(cfg_irq_cnt) + LW'(1)));

   AST_IRQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> !rx_empty); // R10
   AST_TX_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pop |=> (tx_level <= $past(tx_level))); // R9
endmodule

// File: tb/spim_core_tb_top.sv
module spim_core_tb_top;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic en = 0, cpol = 0, cpha = 0, lsb = 0, loopb = 0, cont = 0, flow = 0;
   logic [5:0] div = 6'd1;
   logic [7:0] gap = 8'd0;
   logic [2:0] irqc = 3'd0;
   logic tx_push = 0, rx_pop = 0, rdy = 1, miso = 0;
   logic [7:0] tx_wdata = 0;
   logic tx_full, rx_empty, irq, sclk, mosi, cs_n;
   logic [3:0] tx_level, rx_level;
   logic [7:0] rx_rdata;

   int n_chk = 0, n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spim_core dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_en(en), .cfg_cpol(cpol), .cfg_cpha(cpha),
      .cfg_lsb_first(lsb), .cfg_loopback(loopb), .cfg_cont(cont),
      .cfg_flow_en(flow), .cfg_div(div), .cfg_gap(gap), .cfg_irq_cnt(irqc),
      .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_full(tx_full),
      .tx_level(tx_level), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
      .rx_empty(rx_empty), .rx_level(rx_level), .irq(irq), .sclk(sclk),
      .mosi(mosi), .miso(miso), .cs_n(cs_n), .rdy(rdy)
   );

   function automatic logic [7:0] tw(input int i);
      return 8'(i * 53 + 17);
   endfunction
   function automatic logic [7:0] mw(input int i);
      return 8'(i * 29) ^ 8'hC6;
   endfunction
   function automatic logic wbit(input logic [7:0] w, input int k, input logic l);
      return l ? w[k] : w[7-k];
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // target model and timing monitor
   int mcyc = 0, last_evt = 0, tcount = 0, s_idx = 0, d_idx = 0, nb = 0;
   int terr = 0, togerr = 0, idle_err = 0, high_run = 0, last_gap = 0, cs_falls = 0;
   bit chk_timing = 1;
   logic cs_p = 1, sclk_p = 0;
   logic capbits [8];
   logic [7:0] cap [64];

   always @(negedge clk) begin
      if (rst_n) begin
         mcyc++;
         if (cs_p && !cs_n) begin
            last_gap = high_run;
            cs_falls++;
            tcount = 0; s_idx = 0; d_idx = 0;
            last_evt = mcyc;
            if (!cpha) begin
               miso = wbit(mw(nb), 0, lsb);
               d_idx = 1;
            end
         end else if (!cs_p && cs_n) begin
            if (chk_timing && (mcyc - last_evt != int'(div) + 1)) terr++;
            if (tcount % 16 != 0) togerr++;
            high_run = 0;
         end else if (!cs_n && sclk != sclk_p) begin
            if (chk_timing && (tcount % 16 != 0 || tcount == 0) &&
                (mcyc - last_evt != int'(div) + 1)) terr++;
            last_evt = mcyc;
            tcount++;
            if ((tcount % 2 == 1) == !cpha) begin
               capbits[s_idx] = mosi;
               s_idx++;
            end else if (!(!cpha && tcount % 16 == 0)) begin
               miso = wbit(mw(nb), d_idx, lsb);
               d_idx++;
            end
            if (tcount % 16 == 0) begin
               logic [7:0] b;
               for (int k = 0; k < 8; k++) begin
                  if (lsb) b[k] = capbits[k];
                  else     b[7-k] = capbits[k];
               end
               if (nb < 64) cap[nb] = b;
               nb++;
               s_idx = 0; d_idx = 0;
               if (!cpha) begin
                  miso = wbit(mw(nb), 0, lsb);
                  d_idx = 1;
               end
            end
         end
         if (cs_n) begin
            high_run++;
            if (sclk != cpol) idle_err++;
         end
         cs_p = cs_n;
         sclk_p = sclk;
      end
   end

   int txi = 0;

   task automatic push(input logic [7:0] v);
      @(negedge clk);
      tx_wdata = v; tx_push = 1;
      @(negedge clk);
      tx_push = 0;
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
      terr = 0; togerr = 0; idle_err = 0;
   endtask

   task automatic run_until(input int target_nb);
      int t = 0;
      en = 1;
      while (!(nb >= target_nb && cs_n && tx_level == 0) && t < 5000) begin
         @(negedge clk);
         t++;
      end
      chk(t < 5000, "R12 frame completion", 32'(nb), 32'(target_nb));
      repeat (int'(gap) + 4) @(negedge clk);
      en = 0;
   endtask

   task automatic pop_check(input int idx, input string req);
      logic [7:0] e;
      e = loopb ? tw(idx) : mw(idx);
      chk(rx_rdata == e, req, 32'(rx_rdata), 32'(e));
      chk(cap[idx] == tw(idx), "R3 R4 mosi byte", 32'(cap[idx]), 32'(tw(idx)));
      @(negedge clk); rx_pop = 1;
      @(negedge clk); rx_pop = 0;
   endtask

   task automatic send(input int n, input string req);
      int base, f0;
      base = nb; f0 = cs_falls;
      for (int k = 0; k < n; k++) begin
         push(tw(txi)); txi++;
      end
      run_until(base + n);
      for (int k = 0; k < n; k++) pop_check(base + k, req);
      chk(terr == 0, "R1 half period", 32'(terr), 0);
      chk(togerr == 0, "R2 toggles per frame", 32'(togerr), 0);
      chk(idle_err == 0, "R2 idle level", 32'(idle_err), 0);
      chk(cs_falls - f0 == (cont ? 1 : n), "R7 cs falls", 32'(cs_falls - f0),
          32'(cont ? 1 : n));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      repeat (2) @(negedge clk);
      // R11 reset state
      chk(cs_n == 1, "R11 cs_n", 32'(cs_n), 1);
      chk(sclk == cpol, "R11 sclk", 32'(sclk), 32'(cpol));
      chk(tx_level == 0 && rx_level == 0, "R11 levels", 32'({tx_level, rx_level}), 0);
      chk(rx_empty == 1, "R11 rx_empty", 32'(rx_empty), 1);
      chk(irq == 0, "R11 irq", 32'(irq), 0);

      // R3 R4 sweep over polarity, phase and order
      for (int m = 0; m < 8; m++) begin
         cpol = m[0]; cpha = m[1]; lsb = m[2];
         settle();
         send(2, "R3 R4 miso byte");
      end

      // R1 divider sweep
      cpol = 1; cpha = 1; lsb = 0;
      for (int dv = 0; dv < 6; dv++) begin
         div = 6'(dv);
         settle();
         send(1, "R1 div sweep data");
      end
      div = 6'd1;

      // R6 gap sweep
      for (int g = 0; g < 6; g += 2) begin
         gap = 8'(g);
         settle();
         send(2, "R6 gap data");
         chk(last_gap == g + 1, "R6 cs high cycles", 32'(last_gap), 32'(g + 1));
      end
      gap = 0;

      // R7 continuous
      cont = 1; settle();
      send(3, "R7 continuous data");
      cont = 0;

      // R8 loopback
      loopb = 1; settle();
      send(2, "R8 loopback data");
      loopb = 0;

      // R5 ready handshake
      begin
         int base;
         flow = 1; rdy = 0; chk_timing = 0; settle();
         base = nb;
         push(tw(txi)); txi++;
         en = 1;
         repeat (60) @(negedge clk);
         chk(cs_n == 0, "R5 cs held low while waiting", 32'(cs_n), 0);
         chk(nb == base && tcount == 0, "R5 no sclk edge while not ready",
             32'(tcount), 0);
         rdy = 1;
         run_until(base + 1);
         pop_check(base, "R5 data after ready");
         flow = 0; rdy = 0; settle();
         send(1, "R5 ready ignored when off");
         rdy = 1; chk_timing = 1;
      end

      // R12 enable gating
      settle();
      push(tw(txi)); txi++;
      repeat (50) @(negedge clk);
      chk(cs_n == 1, "R12 no start while disabled", 32'(cs_n), 1);
      chk(tx_level == 1, "R12 byte kept", 32'(tx_level), 1);
      begin
         int base;
         base = nb;
         run_until(base + 1);
         pop_check(base, "R12 data");
      end

      // R9 queue limits and R10 interrupt sweep
      begin
         int base;
         base = nb;
         for (int k = 0; k < 9; k++) begin
            push(tw(txi)); txi++;
         end
         chk(tx_level == 8, "R9 tx level capped", 32'(tx_level), 8);
         chk(tx_full == 1, "R9 tx full", 32'(tx_full), 1);
         txi--;  // ninth push was dropped
         run_until(base + 8);
         chk(rx_level == 8, "R9 rx level", 32'(rx_level), 8);
         push(tw(txi)); txi++;
         run_until(base + 9);
         chk(rx_level == 8, "R9 rx overflow dropped", 32'(rx_level), 8);
         for (int lv = 8; lv >= 0; lv--) begin
            for (int k = 0; k < 8; k++) begin
               irqc = 3'(k);
               #1;
               chk(irq == (lv >= k + 1), "R10 irq threshold", 32'(irq),
                   32'(lv >= k + 1));
            end
            if (lv > 0) pop_check(base + 8 - lv, "R9 rx order kept");
         end
         chk(rx_empty == 1, "R9 rx drained", 32'(rx_empty), 1);
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule